// File: doc/BRIEF.md
# Command Stream Method Header Decoder

This block sits behind a push-buffer fetch unit and turns a flat stream of 32-bit command words into individual method writes. Each write carries a subchannel number, a byte method address and one data word. A word that arrives while no data words are owed is decoded as a header. The header gives a subchannel, a starting method address and a count of data words that follow. The next that-many words are sent out as writes. The word after them is decoded as a header again.

Two header layouts are supported. A static generation select input picks which one applies. The older layout keeps the byte method address directly in the header and has an 11-bit count. The newer layout keeps the method as a dword index and has a 13-bit count. Each layout has an incrementing header kind and a non-incrementing header kind. An incrementing header steps the address by 4 bytes for each data word. A non-incrementing header sends every data word to the same method. A header whose type bits match neither kind is dropped and sets a sticky error flag.

Top module: `cmd_hdr_decoder`

## Requirements
- R1: With `gen_sel`=0, a header with bits 31:29 = 3'b000 is incrementing. Its count is bits 28:18, its subchannel is bits 15:13, and its byte method address is bits 12:0.
- R2: With `gen_sel`=0, a header with bits 31:29 = 3'b010 (bit 30 set) is non-incrementing. It uses the same count, subchannel and method fields as R1.
- R3: With `gen_sel`=1, a header with bits 31:29 = 3'b001 is incrementing. Its count is bits 28:16, its subchannel is bits 15:13, and bits 12:0 hold the method as a dword index, so the byte address is that index times 4.
- R4: With `gen_sel`=1, a header with bits 31:29 = 3'b011 is non-incrementing. It uses the same fields as R3.
- R5: `gen_sel` alone chooses between the two layouts. A word that is a valid header in one layout is decoded according to the layout currently selected.
- R6: After an incrementing header, the k-th data word (k counted from 0) is written to the start address plus 4k. The sum wraps modulo 2^ADDR_W.
- R7: After a non-incrementing header, every data word is written to the header's start address.
- R8: Exactly count words after a header are emitted as writes, in order and with their data unchanged, and the next word is treated as a header. A count of zero produces no write.
- R9: When `out_valid` is high and `out_ready` is low, the outputs stay unchanged on the next cycle. In that state no data word is accepted, so no word is lost or duplicated.
- R10: A header whose type bits are not valid for the selected layout produces no write. It sets `hdr_err`, which stays high until reset. The word after it is decoded as a header.
- R11: During and after reset, `out_valid` and `hdr_err` are low, `in_ready` is high, and the first accepted word is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_sel | input | 1 | Header layout select (0 older, 1 newer), static while words flow |
| in_valid | input | 1 | Command word available |
| in_ready | output | 1 | Command word accepted this cycle when valid |
| in_word | input | 32 | Command word |
| out_valid | output | 1 | Method write available |
| out_ready | input | 1 | Downstream takes the write |
| out_subc | output | 3 | Subchannel of the write |
| out_addr | output | ADDR_W | Byte method address of the write |
| out_data | output | 32 | Data word of the write |
| hdr_err | output | 1 | Sticky unknown-header flag |

## Verification
The bench builds the block with the default ADDR_W of 15. This is the narrowest width that holds the newer layout's largest byte address. With it, an incrementing run that starts at dword index 0x1FFF wraps to zero after one step. An older-layout run that starts at 0x1FFC crosses above the 13-bit field without wrapping. Streams in both layouts, with random input gaps and random output stalls, also push counts of zero and the header-after-error case through the same reference model.

// File: rtl/cmd_hdr_decoder.sv
module cmd_hdr_decoder #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_subc,
  output logic [ADDR_W-1:0] out_addr,
  output logic [31:0]       out_data,
  output logic              hdr_err
);
  localparam int CNT_W = 13;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        subc_q;
  logic              incr_q;

  logic              hdr_ok, hdr_incr;
  logic [CNT_W-1:0]  hdr_cnt;
  logic [ADDR_W-1:0] hdr_addr;
  logic [2:0]        top;

  assign top = in_word[31:29];

  always_comb begin
    if (!gen_sel) begin
      hdr_ok   = (top == 3'b000) || (top == 3'b010);
      hdr_incr = (top == 3'b000);
      hdr_cnt  = {2'b00, in_word[28:18]};
      hdr_addr = ADDR_W'(in_word[12:0]);
    end else begin
      hdr_ok   = (top == 3'b001) || (top == 3'b011);
      hdr_incr = (top == 3'b001);
      hdr_cnt  = in_word[28:16];
      hdr_addr = ADDR_W'({in_word[12:0], 2'b00});
    end
  end

  wire in_hdr = (cnt_q == '0);
  assign in_ready = in_hdr | ~out_valid | out_ready;
  wire take = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      addr_q    <= '0;
      subc_q    <= '0;
      incr_q    <= 1'b0;
      out_valid <= 1'b0;
      out_subc  <= '0;
      out_addr  <= '0;
      out_data  <= '0;
      hdr_err   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        if (in_hdr) begin
          if (hdr_ok) begin
            cnt_q  <= hdr_cnt;
            addr_q <= hdr_addr;
            subc_q <= in_word[15:13];
            incr_q <= hdr_incr;
          end else begin
            hdr_err <= 1'b1;
          end
        end else begin
          out_valid <= 1'b1;
          out_subc  <= subc_q;
          out_addr  <= addr_q;
          out_data  <= in_word;
          cnt_q     <= cnt_q - 1'b1;
          if (incr_q) addr_q <= addr_q + STEP;
        end
      end
    end
  end

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_subc));

  p_no_take_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && cnt_q != '0 |-> !in_ready);

  p_hdr_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && cnt_q == '0 && (!out_valid || out_ready) |=> !out_valid);

  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && cnt_q == '0 && !hdr_ok |=> hdr_err);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |=> hdr_err);

  p_first_hdr_r11: assert property (@(posedge clk)
    !rst_n |=> in_ready && !out_valid && !hdr_err);
endmodule

// File: tb/cmd_hdr_decoder_tb_top.sv
module cmd_hdr_decoder_tb_top;
  localparam int ADDR_W = 15;
  localparam int AMASK = (1 << ADDR_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_sel = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_word = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [2:0] out_subc;
  logic [ADDR_W-1:0] out_addr;
  logic [31:0] out_data;
  logic hdr_err;

  always #2.5 clk = ~clk;

  cmd_hdr_decoder #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .gen_sel(gen_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_subc(out_subc), .out_addr(out_addr), .out_data(out_data),
    .hdr_err(hdr_err));

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] stim_q[$];
  int unsigned exp_subc_q[$], exp_addr_q[$], exp_data_q[$];
  string exp_tag_q[$];

  int unsigned m_cnt = 0, m_addr = 0, m_subc = 0;
  bit m_incr = 0, m_err = 0;
  string m_tag = "";

  bit prev_stall = 0;
  logic [2:0] prev_subc;
  logic [ADDR_W-1:0] prev_addr;
  logic [31:0] prev_data;

  task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_take(input logic [31:0] w);
    int unsigned t;
    t = w[31:29];
    if (m_cnt == 0) begin
      if (!gen_sel && (t == 0 || t == 2)) begin
        m_incr = (t == 0); m_cnt = (w >> 18) & 'h7ff;
        m_addr = w & 'h1fff; m_subc = (w >> 13) & 7;
        m_tag = m_incr ? "R1 R6" : "R2 R7";
      end else if (gen_sel && (t == 1 || t == 3)) begin
        m_incr = (t == 1); m_cnt = (w >> 16) & 'h1fff;
        m_addr = ((w & 'h1fff) * 4) & AMASK; m_subc = (w >> 13) & 7;
        m_tag = m_incr ? "R3 R6 R5" : "R4 R7 R5";
      end else begin
        m_err = 1;
      end
    end else begin
      exp_subc_q.push_back(m_subc);
      exp_addr_q.push_back(m_addr);
      exp_data_q.push_back(w);
      exp_tag_q.push_back(m_tag);
      m_cnt--;
      if (m_incr) m_addr = (m_addr + 4) & AMASK;
    end
  endtask

  task automatic cycle(input int vpct, input int rpct);
    @(negedge clk);
    in_valid = (stim_q.size() != 0) && (($urandom % 100) < vpct);
    in_word = (stim_q.size() != 0) ? stim_q[0] : $urandom;
    out_ready = ($urandom % 100) < rpct;
    #1;
    if (prev_stall) begin
      check(out_valid === 1'b1, "R9 valid held", out_valid, 1);
      check(out_addr === prev_addr && out_data === prev_data && out_subc === prev_subc,
            "R9 outputs held", out_data, prev_data);
    end
    check(hdr_err === m_err, "R10 error flag", hdr_err, m_err);
    if (out_valid && out_ready) begin
      if (exp_data_q.size() == 0) begin
        check(0, "R8 unexpected write", out_data, 0);
      end else begin
        check(out_data === exp_data_q[0], {exp_tag_q[0], " R8 data"}, out_data, exp_data_q[0]);
        check(out_addr === exp_addr_q[0], {exp_tag_q[0], " addr"}, out_addr, exp_addr_q[0]);
        check(out_subc === exp_subc_q[0], {exp_tag_q[0], " subc"}, out_subc, exp_subc_q[0]);
        void'(exp_data_q.pop_front()); void'(exp_addr_q.pop_front());
        void'(exp_subc_q.pop_front()); void'(exp_tag_q.pop_front());
      end
    end
    if (in_valid && in_ready) begin
      model_take(stim_q[0]);
      void'(stim_q.pop_front());
    end
    prev_stall = out_valid && !out_ready;
    prev_subc = out_subc; prev_addr = out_addr; prev_data = out_data;
  endtask

  task automatic run(input int vpct, input int rpct);
    while (!done && (stim_q.size() != 0 || exp_data_q.size() != 0 || out_valid)) cycle(vpct, rpct);
    repeat (3) cycle(vpct, 100);
    check(exp_data_q.size() == 0, "R8 all writes seen", exp_data_q.size(), 0);
  endtask

  function automatic logic [31:0] hdr(input bit g, input int unsigned t, input int unsigned cnt,
                                      input int unsigned subc, input int unsigned m);
    if (!g) return (t << 29) | ((cnt & 'h7ff) << 18) | ((subc & 7) << 13) | (m & 'h1fff);
    return (t << 29) | ((cnt & 'h1fff) << 16) | ((subc & 7) << 13) | (m & 'h1fff);
  endfunction

  task automatic push_cmd(input bit g, input int unsigned t, input int unsigned cnt,
                          input int unsigned subc, input int unsigned m, input bit bad);
    stim_q.push_back(hdr(g, t, cnt, subc, m));
    if (!bad) for (int i = 0; i < int'(cnt); i++) stim_q.push_back($urandom);
  endtask

  task automatic gen_random(input bit g, input int n, input bit allow_bad);
    for (int i = 0; i < n; i++) begin
      int unsigned t;
      bit bad;
      bad = allow_bad && ($urandom % 6 == 0);
      if (bad) begin
        do t = $urandom % 8; while (g ? (t == 1 || t == 3) : (t == 0 || t == 2));
      end else begin
        t = g ? (($urandom % 2) ? 1 : 3) : (($urandom % 2) ? 0 : 2);
      end
      push_cmd(g, t, $urandom % 6, $urandom, $urandom, bad);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R11 out_valid in reset", out_valid, 0);
    check(hdr_err === 1'b0, "R11 hdr_err in reset", hdr_err, 0);
    @(negedge clk); rst_n = 1'b1;
    m_cnt = 0; m_err = 0; prev_stall = 0;
    #1;
    check(in_ready === 1'b1, "R11 in_ready after reset", in_ready, 1);
    check(out_valid === 1'b0, "R11 out_valid after reset", out_valid, 0);
  endtask

  initial begin
    do_reset();
    // older layout, directed: R1 incrementing near 13-bit top, R2, zero count (R8)
    gen_sel = 1'b0;
    push_cmd(0, 0, 3, 5, 'h100, 0);
    push_cmd(0, 2, 4, 2, 'h0a0, 0);
    push_cmd(0, 0, 0, 1, 'h040, 0);
    push_cmd(0, 0, 2, 7, 'h1ffc, 0);
    run(100, 100);
    gen_random(0, 40, 0);
    run(70, 60);
    // newer layout: R3 with address wrap, R4, R5 same word decoded differently
    gen_sel = 1'b1;
    push_cmd(1, 1, 3, 3, 'h1fff, 0);
    push_cmd(1, 3, 3, 6, 'h010, 0);
    push_cmd(1, 1, 0, 0, 'h020, 0);
    run(100, 30);
    gen_random(1, 40, 0);
    run(60, 50);
    // R10: unknown header in newer layout (old incrementing type), then valid header
    push_cmd(1, 0, 2, 1, 'h050, 1);
    push_cmd(1, 1, 2, 4, 'h008, 0);
    run(100, 100);
    check(hdr_err === 1'b1, "R10 sticky after bad header", hdr_err, 1);
    gen_random(1, 40, 1);
    run(80, 40);
    do_reset();
    gen_sel = 1'b0;
    push_cmd(0, 1, 3, 0, 'h000, 1);
    push_cmd(0, 2, 1, 2, 'h1234, 0);
    gen_random(0, 60, 1);
    run(75, 55);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R8 actual=hung expected=drained");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule